// File: doc/BRIEF.md
# Sector Erase Acceptance Window Controller

This block sits on the device side of a flash-style asynchronous write bus. It turns a decoded sector erase command into a timed collection phase followed by an erase launch. When a write carrying the erase command arrives while the block is in read-array mode, the block records the addressed sector in a sector mask and opens an acceptance window. Every later write inside that window, whatever its data, adds the sector named by its address. Each write strobe restarts the window timer. When the timer runs out with no new write, the block issues a one-cycle start pulse and hands the accumulated mask to a downstream erase engine.

Once the erase is running, the block honours only the suspend command. A later erase command resumes the erase. Completion from the engine returns the block to read-array mode and clears the mask. An asynchronous reset aborts everything at once. A status bit shows whether the window has closed. Command unlock decoding happens upstream and arrives as two qualifiers that are held with the write address. The write strobe passes through a synchronizer of `SYNC_STAGES` flops. A write takes effect `SYNC_STAGES+1` clock cycles after `we_n` rises, and the address and qualifiers must stay stable until then.

Top module: `sector_erase_window`

## Requirements
- R1: While reset is asserted and after it is released, `read_mode` is 1, `timer_status` is 0, `erase_mask` is all zero and no pulse output is high.
- R2: In read-array mode, a write with `cmd_erase`=1 and `cmd_suspend`=0 opens the window. It sets mask bit `sect_addr`, where bit i stands for sector i. Afterwards `read_mode` is 0 and `timer_status` is 0.
- R3: With no further write, `erase_start` is high for exactly one cycle. The pulse comes `WIN_CYCLES` cycles after the last write took effect, which is `SYNC_STAGES+1+WIN_CYCLES` cycles after `we_n` rose. From that cycle on, `timer_status` is 1.
- R4: Inside the window, every write with `cmd_suspend`=0 adds its sector whatever the value of `cmd_erase`. Sectors may come in any order and any subset up to all sectors may be chosen. Writing an already selected sector changes nothing.
- R5: `we_n` held low keeps the window open, and expiry is timed from the latest write. A strobe whose fall comes no more than `WIN_CYCLES` cycles after the previous rise keeps the window open and adds its sector. A strobe that falls later finds the erase already started.
- R6: While the erase runs, writes without `cmd_suspend` are ignored. The mask holds, no pulse is issued and `timer_status` stays 1.
- R7: A write with `cmd_suspend`=1 during the erase gives a one-cycle `erase_suspend` pulse, and `timer_status` stays 1. While suspended, only an erase-command write acts: it gives a one-cycle `erase_resume` pulse.
- R8: A suspend write inside the window closes the window without launching. `timer_status` becomes 1 and the suspend write adds no sector. A later erase-command write then gives `erase_start`, not `erase_resume`.
- R9: `eng_done` during the erase returns the block to read-array mode: `read_mode` is 1, the mask is zero and `timer_status` is 0. In read-array mode a write without `cmd_erase` is ignored.
- R10: When `eng_done` and a suspend write take effect in the same cycle, completion wins: the block returns to read-array mode and no `erase_suspend` is issued.
- R11: Asserting `rst_n` aborts a window or an erase at once. While `rst_n` is low, `read_mode` is 1, the mask is zero and `timer_status` is 0, and the aborted window never launches.
- R12: At most one of `erase_start`, `erase_suspend` and `erase_resume` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released internally on the clock |
| we_n | input | 1 | Asynchronous active-low write strobe |
| sect_addr | input | SECT_W | Sector-select upper bits of the write address |
| cmd_erase | input | 1 | Decoded qualifier: this write is the erase command |
| cmd_suspend | input | 1 | Decoded qualifier: this write is the suspend command |
| eng_done | input | 1 | Erase engine reports completion |
| erase_start | output | 1 | One-cycle launch pulse to the erase engine |
| erase_suspend | output | 1 | One-cycle suspend request to the erase engine |
| erase_resume | output | 1 | One-cycle resume request to the erase engine |
| erase_mask | output | 2**SECT_W | Selected sectors, bit i is sector i |
| timer_status | output | 1 | 0 while idle or the window is open, 1 once closed |
| read_mode | output | 1 | 1 when the block is in read-array mode |

## Verification
The critical collision is a new write strobe falling on the very cycle the window would expire. The fall's clearing of the timer and the launch then compete for the same edge. The bench sweeps the fall offset from `WIN_CYCLES-2` to `WIN_CYCLES+2` cycles after the previous rise. Up to an offset of `WIN_CYCLES` it expects the sector to be added and the window to stay open. Beyond that it expects a single start pulse and an unchanged mask. A second collision, completion arriving in the same cycle as a suspend write takes effect, is provoked by timing `eng_done` against the synchronizer latency. The bench judges it by the absence of a suspend pulse and a return to read-array mode.

// File: rtl/sew_pkg.sv
package sew_pkg;

  typedef enum logic [1:0] {
    ST_READ   = 2'd0,
    ST_WINDOW = 2'd1,
    ST_ERASE  = 2'd2,
    ST_SUSP   = 2'd3
  } sew_state_e;

endpackage

// File: rtl/sew_strobe_sync.sv
module sew_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strb_n,
  output logic lvl,
  output logic rise
);

  logic [STAGES-1:0] stg_q;
  logic [STAGES-1:0] stg_d;
  logic              prev_q;

  assign stg_d[0] = strb_n;

  generate
    for (genvar g = 1; g < STAGES; g++) begin : g_chain
      assign stg_d[g] = stg_q[g-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q  <= '1;
      prev_q <= 1'b1;
    end else begin
      stg_q  <= stg_d;
      prev_q <= stg_q[STAGES-1];
    end
  end

  assign lvl  = stg_q[STAGES-1];
  assign rise = lvl & ~prev_q;

endmodule

// File: rtl/sew_window_timer.sv
module sew_window_timer #(
  parameter int WIN_CYCLES = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic expire
);

  localparam int CNT_W = (WIN_CYCLES > 1) ? $clog2(WIN_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WIN_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    if (!run || restart) begin
      cnt_d  = '0;
      cnt_en = (cnt_q != '0);
    end else begin
      cnt_d  = cnt_q + 1'b1;
      cnt_en = (cnt_q != LAST);
    end
    expire = run & ~restart & (cnt_q == LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/sew_sector_buf.sv
module sew_sector_buf #(
  parameter int IDX_W = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  set_en,
  input  logic [IDX_W-1:0]      set_idx,
  input  logic                  clr,
  output logic [(1<<IDX_W)-1:0] mask
);

  localparam int NSECT = 1 << IDX_W;

  generate
    for (genvar g = 0; g < NSECT; g++) begin : g_bit
      logic bit_q;
      logic bit_d;
      logic bit_en;
      logic hit;

      always_comb begin
        hit    = set_en && (set_idx == IDX_W'(g));
        bit_en = clr | hit;
        bit_d  = ~clr;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          bit_q <= 1'b0;
        end else if (bit_en) begin
          bit_q <= bit_d;
        end
      end

      assign mask[g] = bit_q;
    end
  endgenerate

endmodule

// File: rtl/sew_ctrl.sv
module sew_ctrl
  import sew_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rise,
  input  logic       cmd_erase,
  input  logic       cmd_suspend,
  input  logic       expire,
  input  logic       eng_done,
  output sew_state_e state_o,
  output logic       tmr_run,
  output logic       set_en,
  output logic       buf_clr,
  output logic       start_o,
  output logic       susp_o,
  output logic       resume_o
);

  sew_state_e state_q;
  sew_state_e state_d;
  logic       launched_q;
  logic       launched_d;
  logic       start_q;
  logic       start_d;
  logic       susp_q;
  logic       susp_d;
  logic       resume_q;
  logic       resume_d;
  logic       wr_erase;
  logic       wr_susp;

  always_comb begin
    wr_erase   = rise & cmd_erase & ~cmd_suspend;
    wr_susp    = rise & cmd_suspend;
    state_d    = state_q;
    launched_d = launched_q;
    set_en     = 1'b0;
    buf_clr    = 1'b0;
    start_d    = 1'b0;
    susp_d     = 1'b0;
    resume_d   = 1'b0;
    unique case (state_q)
      ST_READ: begin
        if (wr_erase) begin
          set_en     = 1'b1;
          launched_d = 1'b0;
          state_d    = ST_WINDOW;
        end
      end
      ST_WINDOW: begin
        if (wr_susp) begin
          state_d = ST_SUSP;
        end else if (rise) begin
          set_en = 1'b1;
        end else if (expire) begin
          state_d    = ST_ERASE;
          start_d    = 1'b1;
          launched_d = 1'b1;
        end
      end
      ST_ERASE: begin
        if (eng_done) begin
          state_d    = ST_READ;
          buf_clr    = 1'b1;
          launched_d = 1'b0;
        end else if (wr_susp) begin
          state_d = ST_SUSP;
          susp_d  = 1'b1;
        end
      end
      ST_SUSP: begin
        if (wr_erase) begin
          state_d = ST_ERASE;
          if (launched_q) begin
            resume_d = 1'b1;
          end else begin
            start_d    = 1'b1;
            launched_d = 1'b1;
          end
        end
      end
      default: state_d = ST_READ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_READ;
      launched_q <= 1'b0;
      start_q    <= 1'b0;
      susp_q     <= 1'b0;
      resume_q   <= 1'b0;
    end else begin
      state_q    <= state_d;
      launched_q <= launched_d;
      start_q    <= start_d;
      susp_q     <= susp_d;
      resume_q   <= resume_d;
    end
  end

  assign state_o  = state_q;
  assign tmr_run  = (state_q == ST_WINDOW);
  assign start_o  = start_q;
  assign susp_o   = susp_q;
  assign resume_o = resume_q;

endmodule

// File: rtl/sector_erase_window.sv
module sector_erase_window
  import sew_pkg::*;
#(
  parameter int SECT_W      = 3,
  parameter int WIN_CYCLES  = 10000,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we_n,
  input  logic [SECT_W-1:0]       sect_addr,
  input  logic                    cmd_erase,
  input  logic                    cmd_suspend,
  input  logic                    eng_done,
  output logic                    erase_start,
  output logic                    erase_suspend,
  output logic                    erase_resume,
  output logic [(1<<SECT_W)-1:0]  erase_mask,
  output logic                    timer_status,
  output logic                    read_mode
);

  localparam int NSECT = 1 << SECT_W;

  logic [1:0] rst_pipe_q;
  logic       rst_int_n;
  logic       strb_lvl;
  logic       strb_rise;
  logic       tmr_run;
  logic       tmr_restart;
  logic       tmr_expire;
  logic       set_en;
  logic       buf_clr;
  sew_state_e state;
  logic [NSECT-1:0] mask;

  // reset asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_pipe_q[1];

  sew_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .strb_n (we_n),
    .lvl    (strb_lvl),
    .rise   (strb_rise)
  );

  // strobe low or a fresh write restarts the window
  assign tmr_restart = ~strb_lvl | strb_rise;

  sew_window_timer #(.WIN_CYCLES(WIN_CYCLES)) u_timer (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .run     (tmr_run),
    .restart (tmr_restart),
    .expire  (tmr_expire)
  );

  sew_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .rise        (strb_rise),
    .cmd_erase   (cmd_erase),
    .cmd_suspend (cmd_suspend),
    .expire      (tmr_expire),
    .eng_done    (eng_done),
    .state_o     (state),
    .tmr_run     (tmr_run),
    .set_en      (set_en),
    .buf_clr     (buf_clr),
    .start_o     (erase_start),
    .susp_o      (erase_suspend),
    .resume_o    (erase_resume)
  );

  sew_sector_buf #(.IDX_W(SECT_W)) u_buf (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .set_en  (set_en),
    .set_idx (sect_addr),
    .clr     (buf_clr),
    .mask    (mask)
  );

  assign erase_mask   = mask;
  assign timer_status = (state == ST_ERASE) || (state == ST_SUSP);
  assign read_mode    = (state == ST_READ);

endmodule

// File: rtl/sew_checker.sv
module sew_checker #(
  parameter int NSECT = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             erase_start,
  input logic             erase_suspend,
  input logic             erase_resume,
  input logic [NSECT-1:0] erase_mask,
  input logic             timer_status,
  input logic             read_mode
);

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |=> !erase_start); // R3

  AST_START_CLOSES_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |-> (timer_status && !read_mode)); // R3

  AST_WINDOW_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (!read_mode && !timer_status) |-> (erase_mask != '0)); // R2

  AST_BUSY_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (timer_status && $past(timer_status)) |-> (erase_mask == $past(erase_mask))); // R6

  AST_SUSPEND_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    erase_suspend |-> ($past(timer_status) && timer_status)); // R7

  AST_RESUME_FROM_SUSPEND: assert property (@(posedge clk) disable iff (!rst_n)
    erase_resume |-> ($past(timer_status) && timer_status)); // R7

  AST_READ_MASK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    read_mode |-> (erase_mask == '0 && !timer_status)); // R9

  AST_PULSE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({erase_start, erase_suspend, erase_resume})); // R12

endmodule

bind sector_erase_window sew_checker #(.NSECT(NSECT)) u_sew_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .erase_start  (erase_start),
  .erase_suspend(erase_suspend),
  .erase_resume (erase_resume),
  .erase_mask   (erase_mask),
  .timer_status (timer_status),
  .read_mode    (read_mode)
);

// File: tb/sector_erase_window_test.sv
`timescale 1ns/1ps
module sector_erase_window_test;

  localparam int SW   = 3;
  localparam int NS   = 1 << SW;
  localparam int WIN  = 12;
  localparam int SYNC = 2;

  logic          clk;
  logic          rst_n;
  logic          we_n;
  logic [SW-1:0] sect_addr;
  logic          cmd_erase;
  logic          cmd_suspend;
  logic          eng_done;
  logic          erase_start;
  logic          erase_suspend;
  logic          erase_resume;
  logic [NS-1:0] erase_mask;
  logic          timer_status;
  logic          read_mode;

  int checks;
  int fails;
  int n_start;
  int n_susp;
  int n_res;
  int n_multi;

  sector_erase_window #(
    .SECT_W(SW), .WIN_CYCLES(WIN), .SYNC_STAGES(SYNC)
  ) uut (
    .clk(clk), .rst_n(rst_n), .we_n(we_n), .sect_addr(sect_addr),
    .cmd_erase(cmd_erase), .cmd_suspend(cmd_suspend), .eng_done(eng_done),
    .erase_start(erase_start), .erase_suspend(erase_suspend),
    .erase_resume(erase_resume), .erase_mask(erase_mask),
    .timer_status(timer_status), .read_mode(read_mode)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // pulse monitor, sampled mid-cycle
  always @(posedge clk) begin
    #2;
    n_start += int'(erase_start);
    n_susp  += int'(erase_suspend);
    n_res   += int'(erase_resume);
    if ((int'(erase_start) + int'(erase_suspend) + int'(erase_resume)) > 1) n_multi++;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic strobe_fall(input int a, input logic e, input logic s);
    sect_addr   = SW'(a);
    cmd_erase   = e;
    cmd_suspend = s;
    we_n        = 1'b0;
  endtask

  task automatic strobe_rise();
    repeat (4) @(negedge clk);
    we_n = 1'b1;
    repeat (SYNC + 1) @(negedge clk);
    cmd_erase   = 1'b0;
    cmd_suspend = 1'b0;
  endtask

  task automatic wr(input int a, input logic e, input logic s);
    strobe_fall(a, e, s);
    strobe_rise();
  endtask

  task automatic wait_expire();
    int s0;
    s0 = n_start;
    repeat (WIN - 1) @(negedge clk);
    chk("R3 no start before window end", int'(erase_start), 0);
    chk("R3 window still open", int'(timer_status), 0);
    @(negedge clk);
    chk("R3 start at window end", int'(erase_start), 1);
    chk("R3 status after expiry", int'(timer_status), 1);
    @(negedge clk);
    chk("R3 start lasts one cycle", int'(erase_start), 0);
    chk("R3 single start", n_start - s0, 1);
  endtask

  task automatic finish_erase();
    eng_done = 1'b1;
    @(negedge clk);
    eng_done = 1'b0;
    @(negedge clk);
    chk("R9 read mode after done", int'(read_mode), 1);
    chk("R9 mask cleared", int'(erase_mask), 0);
    chk("R9 status cleared", int'(timer_status), 0);
  endtask

  initial begin
    checks = 0; fails = 0;
    n_start = 0; n_susp = 0; n_res = 0; n_multi = 0;
    rst_n = 1'b0; we_n = 1'b1; sect_addr = '0;
    cmd_erase = 1'b0; cmd_suspend = 1'b0; eng_done = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 read mode in reset", int'(read_mode), 1);
    chk("R1 mask in reset", int'(erase_mask), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 read mode", int'(read_mode), 1);
    chk("R1 status", int'(timer_status), 0);
    chk("R1 mask", int'(erase_mask), 0);
    chk("R1 no pulses", n_start + n_susp + n_res, 0);

    // R9: plain write in read mode ignored
    wr(5, 1'b0, 1'b0);
    chk("R9 plain write ignored mode", int'(read_mode), 1);
    chk("R9 plain write ignored mask", int'(erase_mask), 0);

    // R2 / R3 / R6 basic flow
    wr(2, 1'b1, 1'b0);
    chk("R2 window opened", int'(read_mode), 0);
    chk("R2 status open", int'(timer_status), 0);
    chk("R2 sector bit", int'(erase_mask), 1 << 2);
    wait_expire();
    begin
      int s0;
      s0 = n_start + n_susp + n_res;
      wr(6, 1'b0, 1'b0);
      wr(1, 1'b1, 1'b0);
      chk("R6 mask held in erase", int'(erase_mask), 1 << 2);
      chk("R6 no pulses in erase", n_start + n_susp + n_res - s0, 0);
      chk("R6 status held", int'(timer_status), 1);
    end
    finish_erase();

    // R4 / R5: accumulation sweep, 1..all sectors
    for (int n = 1; n <= NS; n++) begin
      int first;
      int expm;
      first = (n * 3) % NS;
      wr(first, 1'b1, 1'b0);
      expm = 1 << first;
      for (int k = 1; k < n; k++) begin
        int sec;
        sec = (first + k * 5) % NS;
        wr(sec, logic'(k[0]), 1'b0);
        expm |= (1 << sec);
        chk("R5 window kept open by writes", int'(timer_status), 0);
      end
      wr(first, 1'b0, 1'b0);
      chk("R4 accumulated mask", int'(erase_mask), expm);
      wait_expire();
      chk("R4 mask handed to engine", int'(erase_mask), expm);
      finish_erase();
    end

    // R5: fall offset sweep around the expiry cycle
    for (int d = WIN - 2; d <= WIN + 2; d++) begin
      int s0;
      wr(0, 1'b1, 1'b0);
      s0 = n_start;
      repeat (d - (SYNC + 1)) @(negedge clk);
      strobe_fall(7, 1'b0, 1'b0);
      strobe_rise();
      if (d <= WIN) begin
        chk("R5 late write restarts window", int'(erase_mask), 8'h81);
        chk("R5 no start yet", n_start - s0, 0);
        chk("R5 status open", int'(timer_status), 0);
        wait_expire();
      end else begin
        chk("R6 write after expiry ignored", int'(erase_mask), 8'h01);
        chk("R5 start already issued", n_start - s0, 1);
        chk("R6 status busy", int'(timer_status), 1);
      end
      finish_erase();
    end

    // R7: suspend during erase, then resume
    wr(3, 1'b1, 1'b0);
    wait_expire();
    begin
      int s0;
      int r0;
      int st0;
      s0 = n_susp; r0 = n_res; st0 = n_start;
      wr(0, 1'b0, 1'b1);
      chk("R7 suspend pulse", n_susp - s0, 1);
      chk("R7 status while suspended", int'(timer_status), 1);
      chk("R7 not read mode", int'(read_mode), 0);
      wr(5, 1'b0, 1'b0);
      chk("R7 plain write while suspended ignored", n_res - r0, 0);
      chk("R7 mask held while suspended", int'(erase_mask), 1 << 3);
      wr(0, 1'b1, 1'b0);
      chk("R7 resume pulse", n_res - r0, 1);
      chk("R7 no second start", n_start - st0, 0);
    end
    finish_erase();

    // R8: suspend inside the window
    wr(4, 1'b1, 1'b0);
    begin
      int st0;
      int r0;
      st0 = n_start; r0 = n_res;
      wr(6, 1'b0, 1'b1);
      chk("R8 window closed", int'(timer_status), 1);
      chk("R8 suspend adds no sector", int'(erase_mask), 1 << 4);
      repeat (WIN + 4) @(negedge clk);
      chk("R8 no launch while suspended", n_start - st0, 0);
      wr(1, 1'b1, 1'b0);
      chk("R8 first launch is start", n_start - st0, 1);
      chk("R8 no resume", n_res - r0, 0);
    end
    finish_erase();

    // R10: completion and suspend write in the same cycle
    wr(2, 1'b1, 1'b0);
    wait_expire();
    begin
      int s0;
      s0 = n_susp;
      strobe_fall(0, 1'b0, 1'b1);
      repeat (4) @(negedge clk);
      we_n = 1'b1;
      repeat (SYNC) @(negedge clk);
      eng_done = 1'b1;
      @(negedge clk);
      eng_done = 1'b0;
      cmd_suspend = 1'b0;
      @(negedge clk);
      chk("R10 completion wins", int'(read_mode), 1);
      chk("R10 no suspend pulse", n_susp - s0, 0);
      chk("R10 mask cleared", int'(erase_mask), 0);
    end

    // R11: reset aborts window and erase
    wr(1, 1'b1, 1'b0);
    wr(5, 1'b0, 1'b0);
    begin
      int st0;
      st0 = n_start;
      rst_n = 1'b0;
      #1;
      chk("R11 abort window read mode", int'(read_mode), 1);
      chk("R11 abort window mask", int'(erase_mask), 0);
      chk("R11 abort window status", int'(timer_status), 0);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (WIN + 6) @(negedge clk);
      chk("R11 aborted window never launches", n_start - st0, 0);
    end
    wr(6, 1'b1, 1'b0);
    wait_expire();
    rst_n = 1'b0;
    #1;
    chk("R11 abort erase read mode", int'(read_mode), 1);
    chk("R11 abort erase status", int'(timer_status), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    chk("R12 at most one pulse per cycle", n_multi, 0);
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
    $finish;
  end

endmodule